// File: doc/BRIEF.md
# Variable-Latency Quality-Configurable Segmented Adder

This block is a 32-bit adder built from four 8-bit segments. The first pass does not wait for the carry to ripple across segment boundaries. Each upper segment instead takes a cheap guess of its carry-in, formed from the two top bits of the segment below. The exact boundary carries are computed alongside the guesses and compared with them. One mismatch flag is kept per boundary.

A quality level is given with every operation. It selects which boundaries must end with an exact result:

- Level 0 accepts every guess.
- Level k recovers the k most significant boundaries.
- The top level recovers all of them and yields the exact sum.

When a boundary that must be recovered has mismatched, the block spends one extra cycle. In that cycle it recomputes the segments with the exact carries on the recovered boundaries. Otherwise the result is ready one cycle after acceptance, so extra latency is paid only where the requested quality needs it.

Operations enter through a valid/ready handshake. Each result is announced by a one-cycle done pulse. A flag tells whether the recovery cycle was taken.

Top module: `qc_adder`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no operation accepted, `ready_o`=1, `done_o`=0, `fixed_o`=0 and `result_o`=0.
- R2: Result bits [8s+7:8s] form segment s (s=0..3). Segment 0 has a carry-in of 0. The guessed carry into segment s≥1 at bit p=8s is `a[p-1]&b[p-1] | ((a[p-1]^b[p-1]) & a[p-2]&b[p-2])`. Each segment result is (a_seg + b_seg + carry-in) mod 256.
- R3: At level 3, an operation with any guessed/exact carry mismatch takes one recovery cycle. Every level-3 result equals (a+b) mod 2^32.
- R4: At level 0, every operation completes one cycle after acceptance with `fixed_o`=0. The result uses guessed carries on all boundaries.
- R5: At level k, boundary s (s=1..3) is recovered when s ≥ 4−k. A recovery cycle occurs exactly when a recovered boundary mismatches. The final result uses exact carries on recovered boundaries and guessed carries elsewhere.
- R6: `ready_o` is 0 for exactly the single recovery cycle. A `valid_i` asserted while `ready_o`=0 is not accepted.
- R7: `done_o` pulses for one cycle per accepted operation: one cycle after acceptance, or two when recovery occurs. `fixed_o`=1 with that pulse exactly when recovery occurred.
- R8: The level is sampled at acceptance. Changing `level_i` during the recovery cycle does not change that operation's result.
- R9: Operations that need no recovery can be accepted on consecutive cycles, giving one result per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation offered |
| ready_o | output | 1 | Block can accept an operation this cycle |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| level_i | input | 2 | Quality level, 0 = loosest, 3 = exact |
| done_o | output | 1 | One-cycle result strobe |
| fixed_o | output | 1 | Result went through the recovery cycle |
| result_o | output | 32 | Sum, held until the next result |

## Verification
A stale held operand or level would show at the next done pulse, when the recovered result no longer matches the accepted operation. A stuck recovery state shows within one cycle as `ready_o` staying low or a missing done pulse. A wrong recovery mask shows as a wrong latency or wrong upper segments. Operand pairs that force carries across each boundary separately are applied at every level, so each mask bit and each guess term is visible in the result or latency on the very next pulse.

// File: rtl/qc_adder_pkg.sv
package qc_adder_pkg;
  typedef enum logic {
    QCA_FIRST   = 1'b0,
    QCA_RECOVER = 1'b1
  } qca_state_e;
endpackage

// File: rtl/qca_carry_sub.sv
// Guessed and exact carries at every segment boundary.
module qca_carry_sub #(
  parameter int unsigned SEG_W = 8,
  parameter int unsigned NB    = 3,
  localparam int unsigned LOW_W = SEG_W * NB
) (
  input  logic [LOW_W-1:0] a_i,
  input  logic [LOW_W-1:0] b_i,
  output logic [NB-1:0]    pred_o,
  output logic [NB-1:0]    exact_o
);
  logic [LOW_W:0] c;
  assign c[0] = 1'b0;

  for (genvar k = 0; k < LOW_W; k++) begin : g_chain
    assign c[k+1] = (a_i[k] & b_i[k]) | ((a_i[k] ^ b_i[k]) & c[k]);
  end

  for (genvar i = 0; i < NB; i++) begin : g_bnd
    localparam int unsigned P = (i + 1) * SEG_W;
    assign pred_o[i]  = (a_i[P-1] & b_i[P-1]) |
                        ((a_i[P-1] ^ b_i[P-1]) & a_i[P-2] & b_i[P-2]);
    assign exact_o[i] = c[P];
  end
endmodule

// File: rtl/qca_quality_sel.sv
// Level k recovers the k most significant boundaries.
module qca_quality_sel #(
  parameter int unsigned NB    = 3,
  parameter int unsigned LVL_W = 2
) (
  input  logic [NB-1:0]    mism_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [NB-1:0]    mask_o,
  output logic             need_o
);
  for (genvar j = 0; j < NB; j++) begin : g_mask
    assign mask_o[j] = (int'(lvl_i) + j) >= int'(NB);
  end
  assign need_o = |(mism_i & mask_o);
endmodule

// File: rtl/qca_seg_adder.sv
module qca_seg_adder #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEG_W  = 8,
  localparam int unsigned NSEG  = DATA_W / SEG_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [NSEG-1:0]   cin_i,
  output logic [DATA_W-1:0] sum_o
);
  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    assign sum_o[s*SEG_W +: SEG_W] = a_i[s*SEG_W +: SEG_W] + b_i[s*SEG_W +: SEG_W]
                                     + SEG_W'(cin_i[s]);
  end
endmodule

// File: rtl/qc_adder.sv
module qc_adder
  import qc_adder_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEG_W  = 8,
  localparam int unsigned NSEG  = DATA_W / SEG_W,
  localparam int unsigned LVL_W = $clog2(NSEG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [LVL_W-1:0]  level_i,
  output logic              done_o,
  output logic              fixed_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int unsigned NB    = NSEG - 1;
  localparam int unsigned LOW_W = SEG_W * NB;

  qca_state_e        state_q;
  logic [DATA_W-1:0] a_q, b_q, op_a, op_b, sum;
  logic [LVL_W-1:0]  lvl_q, op_lvl;
  logic [NB-1:0]     pred, exact, mask;
  logic [NSEG-1:0]   cin;
  logic              need, accept, in_rec;

  assign in_rec  = (state_q == QCA_RECOVER);
  assign ready_o = ~in_rec;
  assign accept  = valid_i & ready_o;

  // recovery recomputes from the held operation
  assign op_a   = in_rec ? a_q   : a_i;
  assign op_b   = in_rec ? b_q   : b_i;
  assign op_lvl = in_rec ? lvl_q : level_i;

  qca_carry_sub #(.SEG_W(SEG_W), .NB(NB)) u_carry (
    .a_i     (op_a[LOW_W-1:0]),
    .b_i     (op_b[LOW_W-1:0]),
    .pred_o  (pred),
    .exact_o (exact)
  );

  qca_quality_sel #(.NB(NB), .LVL_W(LVL_W)) u_qsel (
    .mism_i (pred ^ exact),
    .lvl_i  (op_lvl),
    .mask_o (mask),
    .need_o (need)
  );

  assign cin[0] = 1'b0;
  for (genvar j = 0; j < NB; j++) begin : g_cin
    assign cin[j+1] = (in_rec & mask[j]) ? exact[j] : pred[j];
  end

  qca_seg_adder #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_add (
    .a_i   (op_a),
    .b_i   (op_b),
    .cin_i (cin),
    .sum_o (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= QCA_FIRST;
      a_q      <= '0;
      b_q      <= '0;
      lvl_q    <= '0;
      done_o   <= 1'b0;
      fixed_o  <= 1'b0;
      result_o <= '0;
    end else if (accept) begin
      a_q   <= a_i;
      b_q   <= b_i;
      lvl_q <= level_i;
      if (need) begin
        state_q <= QCA_RECOVER;
        done_o  <= 1'b0;
      end else begin
        result_o <= sum;
        done_o   <= 1'b1;
        fixed_o  <= 1'b0;
      end
    end else if (in_rec) begin
      state_q  <= QCA_FIRST;
      result_o <= sum;
      done_o   <= 1'b1;
      fixed_o  <= 1'b1;
    end else begin
      done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/qc_adder_chk.sv
module qc_adder_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NSEG   = 4,
  parameter int unsigned LVL_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              ready_o,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [LVL_W-1:0]  level_i,
  input logic              done_o,
  input logic              fixed_o,
  input logic [DATA_W-1:0] result_o
);
  logic [DATA_W-1:0] sh_sum;
  logic [LVL_W-1:0]  sh_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_sum <= '0;
      sh_lvl <= '0;
    end else if (valid_i && ready_o) begin
      sh_sum <= a_i + b_i;
      sh_lvl <= level_i;
    end
  end

  AST_RECOVER_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> ready_o);  // R6
  AST_RECOVER_ENDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> (done_o && fixed_o));  // R7
  AST_LEVEL0_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o && level_i == '0) |=> (done_o && !fixed_o));  // R4
  AST_DONE_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(valid_i && ready_o) || $past(!ready_o)));  // R7
  AST_TOP_LEVEL_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && sh_lvl == LVL_W'(NSEG - 1)) |-> (result_o == sh_sum));  // R3
endmodule

bind qc_adder qc_adder_chk #(.DATA_W(DATA_W), .NSEG(NSEG), .LVL_W(LVL_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .ready_o  (ready_o),
  .a_i      (a_i),
  .b_i      (b_i),
  .level_i  (level_i),
  .done_o   (done_o),
  .fixed_o  (fixed_o),
  .result_o (result_o)
);

// File: tb/qc_adder_tb.sv
module qc_adder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSEGS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [1:0]  lvl = '0;
  logic        ready, done, fixed;
  logic [31:0] result;

  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qc_adder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .ready_o(ready),
    .a_i(a), .b_i(b), .level_i(lvl), .done_o(done), .fixed_o(fixed), .result_o(result)
  );

  function automatic logic guess_c(logic [31:0] x, logic [31:0] y, int p);
    return (x[p-1] & y[p-1]) | ((x[p-1] ^ y[p-1]) & x[p-2] & y[p-2]);
  endfunction

  function automatic logic true_c(logic [31:0] x, logic [31:0] y, int p);
    longint unsigned m = (64'd1 << p) - 1;
    longint unsigned lo = (longint'(x) & m) + (longint'(y) & m);
    return logic'((lo >> p) & 1);
  endfunction

  function automatic logic [31:0] model_sum(logic [31:0] x, logic [31:0] y, int k, bit rec);
    logic [31:0] r = '0;
    for (int s = 0; s < NSEGS; s++) begin
      int ci = 0;
      int seg;
      if (s > 0) ci = (rec && s >= NSEGS - k) ? int'(true_c(x, y, 8*s)) : int'(guess_c(x, y, 8*s));
      seg = int'((x >> (8*s)) & 32'hFF) + int'((y >> (8*s)) & 32'hFF) + ci;
      r = r | ((32'(seg) & 32'hFF) << (8*s));
    end
    return r;
  endfunction

  function automatic bit model_need(logic [31:0] x, logic [31:0] y, int k);
    for (int s = 1; s < NSEGS; s++)
      if (s >= NSEGS - k && guess_c(x, y, 8*s) != true_c(x, y, 8*s)) return 1'b1;
    return 1'b0;
  endfunction

  // cycle-by-cycle reference
  bit          m_rec, m_done, m_fixed;
  logic [31:0] m_a, m_b, m_res;
  int          m_lvl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rec = 0; m_done = 0; m_fixed = 0; m_res = '0; m_a = '0; m_b = '0; m_lvl = 0;
    end else if (valid && !m_rec) begin
      m_a = a; m_b = b; m_lvl = int'(lvl);
      if (model_need(a, b, int'(lvl))) begin
        m_rec = 1; m_done = 0;
      end else begin
        m_res = model_sum(a, b, int'(lvl), 1'b0); m_done = 1; m_fixed = 0;
      end
    end else if (m_rec) begin
      m_res = model_sum(m_a, m_b, m_lvl, 1'b1); m_done = 1; m_fixed = 1; m_rec = 0;
    end else begin
      m_done = 0;
    end
  end

  function automatic string res_tag(int k);
    if (k == 3) return "R3";
    if (k == 0) return "R4";
    return "R5";
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(ready == !m_rec, "R6", "ready", 32'(ready), 32'(!m_rec));
      check(done == m_done, "R7", "done", 32'(done), 32'(m_done));
      if (m_done) begin
        check(fixed == m_fixed, "R7", "fixed", 32'(fixed), 32'(m_fixed));
        check(result == m_res, m_fixed ? res_tag(m_lvl) : "R2", "result", result, m_res);
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic do_op(logic [31:0] x, logic [31:0] y, logic [1:0] k,
                       logic [31:0] exp_res, bit exp_fix, string tag);
    int lat = 1;
    @(negedge clk);
    valid = 1'b1; a = x; b = y; lvl = k;
    @(negedge clk);
    valid = 1'b0;
    while (!done && lat < 6) begin @(negedge clk); lat++; end
    check(result == exp_res, tag, "directed result", result, exp_res);
    check(fixed == exp_fix, tag, "directed fixed", 32'(fixed), 32'(exp_fix));
    check(lat == (exp_fix ? 2 : 1), tag, "latency", 32'(lat), exp_fix ? 32'd2 : 32'd1);
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check(ready == 1'b1 && done == 1'b0 && fixed == 1'b0 && result == '0, "R1", "reset outputs",
          {ready, done, fixed, result[28:0]}, 32'h8000_0000);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready == 1'b1 && done == 1'b0 && result == '0, "R1", "after release",
          {ready, done, fixed, result[28:0]}, 32'h8000_0000);

    do_op(32'h1234_5678, 32'h0101_0101, 2'd3, 32'h1335_5779, 1'b0, "R2");
    do_op(32'h0000_00C0, 32'h0000_0040, 2'd0, 32'h0000_0100, 1'b0, "R2");
    do_op(32'h0000_00FF, 32'h0000_0001, 2'd3, 32'h0000_0100, 1'b1, "R3");
    do_op(32'h0000_00FF, 32'h0000_0001, 2'd2, 32'h0000_0000, 1'b0, "R5");
    do_op(32'h0000_00FF, 32'h0000_0001, 2'd0, 32'h0000_0000, 1'b0, "R4");
    do_op(32'h00FF_FFFF, 32'h0000_0001, 2'd1, 32'h01FF_FF00, 1'b1, "R5");
    do_op(32'h00FF_FFFF, 32'h0000_0001, 2'd2, 32'h0100_FF00, 1'b1, "R5");
    do_op(32'h00FF_FFFF, 32'h0000_0001, 2'd3, 32'h0100_0000, 1'b1, "R3");
    do_op(32'hFFFF_FFFF, 32'h0000_0001, 2'd0, 32'hFFFF_FF00, 1'b0, "R4");

    // R6 / R8: offer a new op and change the level during recovery
    @(negedge clk);
    valid = 1'b1; a = 32'h0000_00FF; b = 32'h0000_0001; lvl = 2'd3;
    @(negedge clk);
    check(ready == 1'b0, "R6", "ready low in recovery", 32'(ready), 32'd0);
    a = 32'h5; b = 32'h5; lvl = 2'd0;
    @(negedge clk);
    check(done && fixed && result == 32'h100, "R8", "level held through recovery", result, 32'h100);
    @(negedge clk);
    valid = 1'b0;
    check(done && !fixed && result == 32'hA, "R6", "offer taken only after recovery", result, 32'hA);
    @(negedge clk);
    check(done == 1'b0, "R7", "single done pulse", 32'(done), 32'd0);

    // R9: back-to-back fast ops
    @(negedge clk);
    valid = 1'b1; a = 32'h10; b = 32'h20; lvl = 2'd0;
    @(negedge clk);
    a = 32'h30;
    check(done && result == 32'h30, "R9", "first of burst", result, 32'h30);
    @(negedge clk);
    a = 32'h40;
    check(done && result == 32'h50, "R9", "second of burst", result, 32'h50);
    @(negedge clk);
    valid = 1'b0;
    check(done && result == 32'h60, "R9", "third of burst", result, 32'h60);

    // random traffic, reference model compares every clock
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      valid = ($urandom % 4) != 0;
      a = $urandom;
      case ($urandom % 3)
        0: b = ~a + ($urandom % 4);
        1: b = $urandom & 32'h00C0_C0C0;
        default: b = $urandom;
      endcase
      lvl = 2'($urandom % 4);
    end
    @(negedge clk);
    valid = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule